// File: doc/BRIEF.md
# Split-Buffer Dual FIFO with Freeze Mode

This block keeps one RAM and divides it into two circular queues. The inbound queue carries words from a host toward a local processor. The outbound queue carries words from the local processor toward the host. A boundary register sets where the split falls. The inbound queue uses addresses 0 up to boundary−1. The outbound queue uses boundary up to DEPTH−1. Each queue has a write pointer, a read pointer, an occupancy counter and a threshold register. A flag is raised when the occupancy reaches the threshold.

The local processor reaches everything through a small register map. A run bit in the control register picks the operating mode. With the run bit at 1 (running), the pointers, boundary and thresholds can only be read. With the run bit at 0 (frozen), those registers can also be written, so firmware can repair or reshape the buffer. While frozen, all queue traffic stops. Writing a read pointer fetches the word at the new address at once. Writing the boundary empties both queues.

Top module: `sbf_dual_fifo`

## Requirements
- R1: After reset the run bit reads 1 and the boundary reads DEPTH/2. Both thresholds read DEPTH/2. The inbound pointers read 0, the outbound pointers read DEPTH/2, and the status register reads 0x09.
- R2: Words pushed on `hostInPush` leave in arrival order. The register at address 9 always shows the oldest word, and `locInPop` advances to the next one. The inbound pointers wrap from boundary−1 back to 0.
- R3: A write to address 11 while running pushes the word into the outbound queue. `hostOutData` shows the oldest outbound word, and `hostOutPop` advances it. A read of address 11 returns the last value written there.
- R4: A push into a full queue is ignored, and so is a pop from an empty queue. Status register bits: 0 inbound empty, 1 inbound full, 2 inbound threshold, 3 outbound empty, 4 outbound full, 5 outbound threshold.
- R5: A threshold bit is 1 exactly when that queue's occupancy is greater than or equal to its threshold register. The inbound threshold is at address 7 and the outbound threshold at address 8.
- R6: While running, writes to addresses 2 to 8 are ignored. These are inbound write/read pointer, outbound write/read pointer, boundary, inbound threshold and outbound threshold.
- R7: Writing 0 to control bit 0 (address 0) freezes the block. While frozen, addresses 2 to 8 accept writes and all push and pop requests are ignored. Traffic is accepted again from the first cycle after the run bit returns to 1.
- R8: A write to the inbound read pointer (address 3) loads the address-9 register with the buffer word at the new address.
- R9: A write to the outbound read pointer (address 5) loads `hostOutData` with the buffer word at the new address.
- R10: A boundary write (address 6) sets both inbound pointers to 0 and both outbound pointers to the new boundary. It also empties both queues.
- R11: A pointer write recomputes that queue's occupancy as (write − read) modulo the queue size.
- R12: In both modes, writes to the status register (1) and the command-in register (10) are ignored. The command-in register loads from `hostCmdData` on `hostCmdWr`. The command-out register (12) reads back what was written and drives `hostCmdOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 4 | Register address |
| cpuWrEn | input | 1 | Register write strobe |
| cpuWrData | input | DW | Register write data |
| cpuRdData | output | DW | Register read data, combinational from cpuAddr |
| locInPop | input | 1 | Local processor pops the inbound queue |
| hostInPush | input | 1 | Host pushes into the inbound queue |
| hostInData | input | DW | Inbound push data |
| hostOutPop | input | 1 | Host pops the outbound queue |
| hostOutData | output | DW | Oldest outbound word |
| hostCmdWr | input | 1 | Host loads the command-in register |
| hostCmdData | input | DW | Command-in data |
| hostCmdOut | output | DW | Command-out register value |
| hostInFull | output | 1 | Inbound queue full |
| hostOutEmpty | output | 1 | Outbound queue empty |

## Verification
The assertions assume the boundary is only ever written with a value between 1 and DEPTH−1. They also assume a pointer written while frozen lies inside its own queue's address range, because otherwise occupancy and wrap behaviour are undefined. The stimulus keeps to both rules: it sets the boundary to 4 or leaves it at its reset value, and it writes read pointers only to addresses inside the matching queue. With a single address bus, at most one register write can occur per cycle, and the occupancy checks depend on that.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic [3:0] {
    A_CTRL    = 4'd0,
    A_STAT    = 4'd1,
    A_INWR    = 4'd2,
    A_INRD    = 4'd3,
    A_OUTWR   = 4'd4,
    A_OUTRD   = 4'd5,
    A_BOUND   = 4'd6,
    A_INTHR   = 4'd7,
    A_OUTTHR  = 4'd8,
    A_FIFOIN  = 4'd9,
    A_CMDIN   = 4'd10,
    A_FIFOOUT = 4'd11,
    A_CMDOUT  = 4'd12
  } regAddrT;

  typedef struct packed {
    logic wrInWr;
    logic wrInRd;
    logic wrOutWr;
    logic wrOutRd;
    logic wrBound;
    logic wrInThr;
    logic wrOutThr;
    logic pushIn;
    logic popIn;
    logic pushOut;
    logic popOut;
  } strbT;

endpackage

// File: rtl/sbf_ctrl.sv
module sbf_ctrl
  import sbf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    cpuAddr,
  input  logic          cpuWrEn,
  input  logic [DW-1:0] cpuWrData,
  input  logic          locInPop,
  input  logic          hostInPush,
  input  logic          hostOutPop,
  input  logic          hostCmdWr,
  input  logic [DW-1:0] hostCmdData,
  input  logic          inFull,
  input  logic          inEmpty,
  input  logic          outFull,
  input  logic          outEmpty,
  output strbT          strb,
  output logic          runMode,
  output logic [DW-1:0] cmdInQ,
  output logic [DW-1:0] cmdOutQ,
  output logic [DW-1:0] fifoOutQ
);

  logic cfgWr;
  assign cfgWr = cpuWrEn && !runMode;

  always_comb begin
    strb = '0;
    case (cpuAddr)
      A_INWR:   strb.wrInWr   = cfgWr;
      A_INRD:   strb.wrInRd   = cfgWr;
      A_OUTWR:  strb.wrOutWr  = cfgWr;
      A_OUTRD:  strb.wrOutRd  = cfgWr;
      A_BOUND:  strb.wrBound  = cfgWr;
      A_INTHR:  strb.wrInThr  = cfgWr;
      A_OUTTHR: strb.wrOutThr = cfgWr;
      A_FIFOOUT: strb.pushOut = cpuWrEn && runMode && !outFull;
      default: ;
    endcase
    strb.pushIn = hostInPush && runMode && !inFull;
    strb.popIn  = locInPop && runMode && !inEmpty;
    strb.popOut = hostOutPop && runMode && !outEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runMode  <= 1'b1;
      cmdInQ   <= '0;
      cmdOutQ  <= '0;
      fifoOutQ <= '0;
    end else begin
      if (cpuWrEn && cpuAddr == A_CTRL)    runMode  <= cpuWrData[0];
      if (cpuWrEn && cpuAddr == A_CMDOUT)  cmdOutQ  <= cpuWrData;
      if (cpuWrEn && cpuAddr == A_FIFOOUT) fifoOutQ <= cpuWrData;
      if (hostCmdWr)                       cmdInQ   <= hostCmdData;
    end
  end

endmodule

// File: rtl/sbf_datapath.sv
module sbf_datapath
  import sbf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strbT          strb,
  input  logic          runMode,
  input  logic [DW-1:0] cfgData,
  input  logic [DW-1:0] inPushData,
  input  logic [DW-1:0] outPushData,
  output logic [AW-1:0] inWr,
  output logic [AW-1:0] inRd,
  output logic [AW-1:0] outWr,
  output logic [AW-1:0] outRd,
  output logic [AW-1:0] bound,
  output logic [CW-1:0] inThr,
  output logic [CW-1:0] outThr,
  output logic          inEmpty,
  output logic          inFull,
  output logic          inThrHit,
  output logic          outEmpty,
  output logic          outFull,
  output logic          outThrHit,
  output logic [DW-1:0] inHead,
  output logic [DW-1:0] outHead
);

  localparam logic [CW-1:0] DEPTH_C   = CW'(DEPTH);
  localparam logic [AW-1:0] BOUND_RST = AW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] THR_RST   = CW'(DEPTH / 2);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] inCount, outCount, inSize, outSize;
  logic [AW-1:0] inWrNext, inRdNext, outWrNext, outRdNext, newPtr;

  function automatic logic [CW-1:0] ringDist(input logic [AW-1:0] w, input logic [AW-1:0] r,
                                             input logic [CW-1:0] size);
    if (w >= r) ringDist = {1'b0, w} - {1'b0, r};
    else        ringDist = {1'b0, w} + size - {1'b0, r};
  endfunction

  assign newPtr    = cfgData[AW-1:0];
  assign inSize    = {1'b0, bound};
  assign outSize   = DEPTH_C - inSize;
  assign inWrNext  = (inWr == bound - 1'b1) ? '0 : inWr + 1'b1;
  assign inRdNext  = (inRd == bound - 1'b1) ? '0 : inRd + 1'b1;
  assign outWrNext = (outWr == LAST_ADDR) ? bound : outWr + 1'b1;
  assign outRdNext = (outRd == LAST_ADDR) ? bound : outRd + 1'b1;

  assign inEmpty   = (inCount == '0);
  assign inFull    = (inCount == inSize);
  assign inThrHit  = (inCount >= inThr);
  assign outEmpty  = (outCount == '0);
  assign outFull   = (outCount == outSize);
  assign outThrHit = (outCount >= outThr);

  // Pointers, occupancy and boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bound    <= BOUND_RST;
      inWr     <= '0;
      inRd     <= '0;
      outWr    <= BOUND_RST;
      outRd    <= BOUND_RST;
      inCount  <= '0;
      outCount <= '0;
    end else if (strb.wrBound) begin
      bound    <= newPtr;
      inWr     <= '0;
      inRd     <= '0;
      outWr    <= newPtr;
      outRd    <= newPtr;
      inCount  <= '0;
      outCount <= '0;
    end else begin
      if (strb.wrInWr) begin
        inWr    <= newPtr;
        inCount <= ringDist(newPtr, inRd, inSize);
      end else if (strb.wrInRd) begin
        inRd    <= newPtr;
        inCount <= ringDist(inWr, newPtr, inSize);
      end else begin
        if (strb.pushIn) inWr <= inWrNext;
        if (strb.popIn)  inRd <= inRdNext;
        inCount <= inCount + CW'(strb.pushIn) - CW'(strb.popIn);
      end
      if (strb.wrOutWr) begin
        outWr    <= newPtr;
        outCount <= ringDist(newPtr, outRd, outSize);
      end else if (strb.wrOutRd) begin
        outRd    <= newPtr;
        outCount <= ringDist(outWr, newPtr, outSize);
      end else begin
        if (strb.pushOut) outWr <= outWrNext;
        if (strb.popOut)  outRd <= outRdNext;
        outCount <= outCount + CW'(strb.pushOut) - CW'(strb.popOut);
      end
    end
  end

  // Threshold registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inThr  <= THR_RST;
      outThr <= THR_RST;
    end else begin
      if (strb.wrInThr)  inThr  <= cfgData[CW-1:0];
      if (strb.wrOutThr) outThr <= cfgData[CW-1:0];
    end
  end

  // Shared buffer storage
  always_ff @(posedge clk) begin
    if (strb.pushIn)  mem[inWr]  <= inPushData;
    if (strb.pushOut) mem[outWr] <= outPushData;
  end

  // Head-of-queue data registers with prefetch on read-pointer writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inHead  <= '0;
      outHead <= '0;
    end else begin
      if (strb.wrInRd)
        inHead <= mem[newPtr];
      else if (strb.popIn)
        inHead <= (strb.pushIn && inWr == inRdNext) ? inPushData : mem[inRdNext];
      else if (strb.pushIn && inEmpty)
        inHead <= inPushData;

      if (strb.wrOutRd)
        outHead <= mem[newPtr];
      else if (strb.popOut)
        outHead <= (strb.pushOut && outWr == outRdNext) ? outPushData : mem[outRdNext];
      else if (strb.pushOut && outEmpty)
        outHead <= outPushData;
    end
  end

  // R4: occupancy never exceeds the size of its queue
  a_r4_in_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    inCount <= inSize);
  a_r4_out_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    outCount <= outSize);

  // R6: the boundary cannot move while running
  a_r6_bound_locked: assert property (@(posedge clk) disable iff (!rstN)
    runMode |=> $stable(bound));

  // R7: while frozen, only register writes move occupancy
  a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!runMode && !strb.wrInWr && !strb.wrInRd && !strb.wrOutWr && !strb.wrOutRd && !strb.wrBound)
      |=> ($stable(inCount) && $stable(outCount)));

  // R10: a boundary write empties both queues and reseats the pointers
  a_r10_bound_reset: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBound |=> (inWr == '0 && inRd == '0 && outWr == bound && outRd == bound
                      && inEmpty && outEmpty));

endmodule

// File: rtl/sbf_dual_fifo.sv
module sbf_dual_fifo
  import sbf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    cpuAddr,
  input  logic          cpuWrEn,
  input  logic [DW-1:0] cpuWrData,
  output logic [DW-1:0] cpuRdData,
  input  logic          locInPop,
  input  logic          hostInPush,
  input  logic [DW-1:0] hostInData,
  input  logic          hostOutPop,
  output logic [DW-1:0] hostOutData,
  input  logic          hostCmdWr,
  input  logic [DW-1:0] hostCmdData,
  output logic [DW-1:0] hostCmdOut,
  output logic          hostInFull,
  output logic          hostOutEmpty
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  strbT          strb;
  logic          runMode;
  logic [DW-1:0] cmdInQ, cmdOutQ, fifoOutQ, inHead, outHead;
  logic [AW-1:0] inWr, inRd, outWr, outRd, bound;
  logic [CW-1:0] inThr, outThr;
  logic          inEmpty, inFull, inThrHit, outEmpty, outFull, outThrHit;

  sbf_ctrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData),
    .locInPop(locInPop), .hostInPush(hostInPush), .hostOutPop(hostOutPop),
    .hostCmdWr(hostCmdWr), .hostCmdData(hostCmdData),
    .inFull(inFull), .inEmpty(inEmpty), .outFull(outFull), .outEmpty(outEmpty),
    .strb(strb), .runMode(runMode), .cmdInQ(cmdInQ), .cmdOutQ(cmdOutQ), .fifoOutQ(fifoOutQ)
  );

  sbf_datapath #(.DW(DW), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .runMode(runMode), .cfgData(cpuWrData),
    .inPushData(hostInData), .outPushData(cpuWrData),
    .inWr(inWr), .inRd(inRd), .outWr(outWr), .outRd(outRd), .bound(bound),
    .inThr(inThr), .outThr(outThr),
    .inEmpty(inEmpty), .inFull(inFull), .inThrHit(inThrHit),
    .outEmpty(outEmpty), .outFull(outFull), .outThrHit(outThrHit),
    .inHead(inHead), .outHead(outHead)
  );

  always_comb begin
    case (cpuAddr)
      A_CTRL:    cpuRdData = DW'(runMode);
      A_STAT:    cpuRdData = DW'({outThrHit, outFull, outEmpty, inThrHit, inFull, inEmpty});
      A_INWR:    cpuRdData = DW'(inWr);
      A_INRD:    cpuRdData = DW'(inRd);
      A_OUTWR:   cpuRdData = DW'(outWr);
      A_OUTRD:   cpuRdData = DW'(outRd);
      A_BOUND:   cpuRdData = DW'(bound);
      A_INTHR:   cpuRdData = DW'(inThr);
      A_OUTTHR:  cpuRdData = DW'(outThr);
      A_FIFOIN:  cpuRdData = inHead;
      A_CMDIN:   cpuRdData = cmdInQ;
      A_FIFOOUT: cpuRdData = fifoOutQ;
      A_CMDOUT:  cpuRdData = cmdOutQ;
      default:   cpuRdData = '0;
    endcase
  end

  assign hostOutData  = outHead;
  assign hostCmdOut   = cmdOutQ;
  assign hostInFull   = inFull;
  assign hostOutEmpty = outEmpty;

endmodule

// File: tb/tb_sbf_dual_fifo.sv
`timescale 1ns/1ps
module tb_sbf_dual_fifo;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cpuAddr = '0;
  logic       cpuWrEn = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic       locInPop = 1'b0;
  logic       hostInPush = 1'b0;
  logic [7:0] hostInData = '0;
  logic       hostOutPop = 1'b0;
  logic [7:0] hostOutData;
  logic       hostCmdWr = 1'b0;
  logic [7:0] hostCmdData = '0;
  logic [7:0] hostCmdOut;
  logic       hostInFull, hostOutEmpty;

  int nChecks = 0;
  int nErrors = 0;

  sbf_dual_fifo #(.DW(8), .DEPTH(16)) dut (.*);

  always #2 clk = ~clk;

  // {isWrite, requirement number, address, data-or-expected}
  localparam int NV = 20;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'd1,  4'd0,  8'h01},  // R1 run bit
    {1'b0, 4'd1,  4'd6,  8'h08},  // R1 boundary
    {1'b0, 4'd1,  4'd4,  8'h08},  // R1 outbound write pointer
    {1'b0, 4'd1,  4'd1,  8'h09},  // R1 status
    {1'b1, 4'd6,  4'd2,  8'h05},  // R6 pointer write while running
    {1'b0, 4'd6,  4'd2,  8'h00},
    {1'b1, 4'd6,  4'd6,  8'h04},  // R6 boundary write while running
    {1'b0, 4'd6,  4'd6,  8'h08},
    {1'b1, 4'd12, 4'd1,  8'hFF},  // R12 status write ignored
    {1'b0, 4'd12, 4'd1,  8'h09},
    {1'b1, 4'd12, 4'd12, 8'h5A},  // R12 command-out read back
    {1'b0, 4'd12, 4'd12, 8'h5A},
    {1'b1, 4'd7,  4'd0,  8'h00},  // R7 freeze
    {1'b0, 4'd7,  4'd0,  8'h00},
    {1'b1, 4'd7,  4'd7,  8'h02},  // R7 threshold writable when frozen
    {1'b0, 4'd7,  4'd7,  8'h02},
    {1'b1, 4'd12, 4'd10, 8'h33},  // R12 command-in write ignored
    {1'b0, 4'd12, 4'd10, 8'h00},
    {1'b1, 4'd7,  4'd0,  8'h01},  // R7 run again
    {1'b0, 4'd7,  4'd0,  8'h01}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [7:0] d);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(posedge clk); #1;
    cpuWrEn = 1'b0;
  endtask

  task automatic regChk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    cpuAddr = a; #1;
    check(cpuRdData, exp, tag);
  endtask

  task automatic push(input logic [7:0] d);
    hostInPush = 1'b1; hostInData = d;
    @(posedge clk); #1;
    hostInPush = 1'b0;
  endtask

  task automatic popIn();
    locInPop = 1'b1;
    @(posedge clk); #1;
    locInPop = 1'b0;
  endtask

  task automatic popOut();
    hostOutPop = 1'b1;
    @(posedge clk); #1;
    hostOutPop = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired actual=hang expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) regWr(VEC[i][11:8], VEC[i][7:0]);
      else regChk(VEC[i][11:8], VEC[i][7:0], $sformatf("R%0d table entry %0d", VEC[i][15:12], i));
    end

    // R10: boundary write while frozen
    regWr(4'd0, 8'h00);
    regWr(4'd6, 8'h04);
    regChk(4'd2, 8'h00, "R10 inbound write pointer");
    regChk(4'd3, 8'h00, "R10 inbound read pointer");
    regChk(4'd4, 8'h04, "R10 outbound write pointer");
    regChk(4'd5, 8'h04, "R10 outbound read pointer");
    regChk(4'd1, 8'h09, "R10 both queues empty");
    regWr(4'd0, 8'h01);

    // R2/R4/R5: fill the 4-word inbound queue
    for (int i = 0; i < 4; i++) push(8'hB0 + 8'(i));
    regChk(4'd9, 8'hB0, "R2 oldest word at head");
    regChk(4'd1, 8'h0E, "R4 R5 full and threshold status");
    check({7'b0, hostInFull}, 8'h01, "R4 full port");
    push(8'hB4);
    regChk(4'd2, 8'h00, "R4 push into full ignored, pointer wrapped");
    for (int i = 0; i < 4; i++) begin
      regChk(4'd9, 8'hB0 + 8'(i), "R2 arrival order");
      popIn();
    end
    popIn();
    regChk(4'd3, 8'h00, "R4 pop from empty ignored, read pointer wrapped");
    regChk(4'd1, 8'h09, "R4 empty again");

    // R7: traffic blocked while frozen, resumes the next cycle
    regWr(4'd0, 8'h00);
    push(8'hEE);
    regChk(4'd2, 8'h00, "R7 push ignored while frozen");
    regChk(4'd1, 8'h09, "R7 status unchanged while frozen");
    regWr(4'd0, 8'h01);
    push(8'hC0);
    regChk(4'd2, 8'h01, "R7 push accepted right after run");
    regChk(4'd9, 8'hC0, "R2 push into empty reaches head");

    // R8/R11: rewrite inbound read pointer
    regWr(4'd0, 8'h00);
    regWr(4'd3, 8'h02);
    regChk(4'd9, 8'hB2, "R8 prefetch at new read pointer");
    cpuAddr = 4'd1; #1;
    check({5'b0, cpuRdData[2:0]}, 8'h04, "R11 occupancy 3 from pointers");
    regWr(4'd0, 8'h01);
    popIn();
    regChk(4'd9, 8'hB3, "R11 pop after rewrite");
    popIn();
    regChk(4'd9, 8'hC0, "R2 wrap to address 0");
    regChk(4'd3, 8'h00, "R2 read pointer wrapped");

    // R3/R12: outbound queue
    regWr(4'd11, 8'hD0);
    regWr(4'd11, 8'hD1);
    check(hostOutData, 8'hD0, "R3 outbound head");
    regChk(4'd11, 8'hD1, "R12 outbound data register read back");
    popOut();
    check(hostOutData, 8'hD1, "R3 outbound order");
    check({7'b0, hostOutEmpty}, 8'h00, "R3 not empty");
    popOut();
    check({7'b0, hostOutEmpty}, 8'h01, "R3 empty after two pops");

    // R9/R11: rewrite outbound read pointer
    regWr(4'd0, 8'h00);
    regWr(4'd5, 8'h04);
    check(hostOutData, 8'hD0, "R9 outbound prefetch");
    check({7'b0, hostOutEmpty}, 8'h00, "R11 outbound occupancy recomputed");
    regChk(4'd5, 8'h04, "R9 read pointer written");

    // R5: outbound threshold
    regWr(4'd8, 8'h02);
    cpuAddr = 4'd1; #1;
    check({7'b0, cpuRdData[5]}, 8'h01, "R5 outbound threshold reached");
    regWr(4'd8, 8'h03);
    cpuAddr = 4'd1; #1;
    check({7'b0, cpuRdData[5]}, 8'h00, "R5 outbound threshold not reached");
    regWr(4'd0, 8'h01);

    // R12: host command registers
    hostCmdWr = 1'b1; hostCmdData = 8'h77;
    @(posedge clk); #1;
    hostCmdWr = 1'b0;
    regChk(4'd10, 8'h77, "R12 command-in loaded by host");
    check(hostCmdOut, 8'h5A, "R12 command-out port");

    finishRun();
  end

endmodule